// File: doc/BRIEF.md
# Holdover Frequency History Averager

This block keeps a running history of fractional-frequency words reported by a locked PLL channel and, on request, computes the frequency to use when the channel drops into holdover. Each history tick brings one signed sample on `sample_i` with a one-cycle `sample_vld_i` strobe. Samples are written into a circular store of fixed depth, but only while `locked_i` is high. The store holds 120 ticks by default, and a tick is meant to be one second.

The average is taken over a programmable number of samples, the window. The window does not start at the newest sample: a programmable number of the newest samples, the delay, is skipped first. This keeps readings taken just before an input failure out of the result. The history is reported valid only once window plus delay samples have been recorded without a break in lock.

A pulse on `capture_i` starts a sequential engine. It sums the selected samples one per cycle, then divides by the window length with a restoring divider. The result appears on `avg_o` together with a one-cycle `avg_done_o` pulse, and it holds until the next result.

Top module: `holdover_hist_avg`

## Requirements
- R1: The store holds DEPTH samples (default 120). Each accepted sample overwrites the oldest one once the store is full.
- R2: A sample is recorded only when `sample_vld_i` and `locked_i` are both high. A strobe while unlocked changes neither the history nor any later result.
- R3: The result is the sum of the W samples that come just before the newest D recorded samples, divided by W and truncated toward zero. It is a signed two's-complement value of DATA_W bits.
- R4: When `win_len_i` is 0, the default window of 9 and the default delay of 2 are used, and `dly_len_i` is ignored.
- R5: A window larger than DEPTH is cut to DEPTH. The delay is then cut to at most DEPTH minus the window.
- R6: `hist_valid_o` is high only after W+D consecutive samples have been recorded while locked. Any cycle with `locked_i` low clears that count to zero.
- R7: A capture while the history is not valid returns the most recently recorded sample, or 0 if nothing has been recorded since reset.
- R8: Each accepted capture gives exactly one single-cycle `avg_done_o` pulse. A capture that arrives while a computation is running is ignored.
- R9: `avg_o` changes only in the cycle where `avg_done_o` is high. Later samples and setting changes do not move it.
- R10: While reset is held, `avg_o`, `avg_done_o` and `hist_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | DATA_W | Signed fractional-frequency sample |
| sample_vld_i | input | 1 | One-cycle strobe per history tick |
| locked_i | input | 1 | Channel is in locked operation |
| win_len_i | input | CNT_W | Window length in ticks (0 selects the defaults) |
| dly_len_i | input | CNT_W | Number of newest samples to skip |
| capture_i | input | 1 | Start an average computation |
| avg_o | output | DATA_W | Held signed average |
| avg_done_o | output | 1 | One-cycle pulse when `avg_o` is updated |
| hist_valid_o | output | 1 | History long enough for the chosen window and delay |

## Verification
The averaging is tried with the following patterns, each aimed at a specific fault:
- Rising positive ramps, so that a window shifted by even one slot gives a different sum.
- Negative values whose sums do not divide evenly, which separates truncation toward zero from flooring.
- A window of zero, to exercise the default settings.
- Oversized windows and delays, to exercise clamping.
- A lock loss with a large sample strobed in while unlocked. After relock, a capture that is not yet valid must return the newest locked sample, and a valid capture must use only samples taken after the relock.

// File: rtl/hha_pkg.sv
package hha_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_LOAD,
    ST_WAIT
  } avg_state_e;
endpackage

// File: rtl/hha_clamp.sv
module hha_clamp #(
  parameter int DEPTH   = 120,
  parameter int CNT_W   = 7,
  parameter int DEF_WIN = 9,
  parameter int DEF_DLY = 2
) (
  input  logic [CNT_W-1:0] win_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic [CNT_W-1:0] win_o,
  output logic [CNT_W-1:0] dly_o
);
  localparam logic [CNT_W-1:0] DepthC = CNT_W'(DEPTH);

  logic [CNT_W-1:0] w_t, d_t, room;

  always_comb begin
    if (win_i == '0) begin
      w_t = CNT_W'(DEF_WIN);
      d_t = CNT_W'(DEF_DLY);
    end else begin
      w_t = win_i;
      d_t = dly_i;
    end
    if (w_t > DepthC) w_t = DepthC;
    room = DepthC - w_t;
    if (d_t > room) d_t = room;
  end

  assign win_o = w_t;
  assign dly_o = d_t;
endmodule

// File: rtl/hha_history.sv
module hha_history #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 120,
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic                     sample_vld_i,
  input  logic                     locked_i,
  input  logic        [PTR_W-1:0]  rd_idx_i,
  output logic signed [DATA_W-1:0] rd_data_o,
  output logic        [PTR_W-1:0]  wr_ptr_o,
  output logic        [CNT_W-1:0]  run_cnt_o
);
  logic signed [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0] run_q;
  logic             wr_en;

  assign wr_en = sample_vld_i & locked_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en && (wr_ptr_q == PTR_W'(g))) mem_q[g] <= sample_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
    end else if (wr_en) begin
      wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
  end

  // consecutive locked samples, saturating at the depth
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (!locked_i) run_q <= '0;
    else if (sample_vld_i && (run_q < CNT_W'(DEPTH))) run_q <= run_q + 1'b1;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign wr_ptr_o  = wr_ptr_q;
  assign run_cnt_o = run_q;

  a_r6_unlock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> (run_q == '0));
  a_r2_no_write_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> $stable(wr_ptr_q));
  a_r1_ptr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ptr_q < PTR_W'(DEPTH));
endmodule

// File: rtl/hha_div.sv
module hha_div #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int StepW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [StepW-1:0] step_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   shifted, trial;
  logic             fits;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign trial   = shifted - {1'b0, den_q};
  assign fits    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        step_q <= StepW'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? DEN_W'(trial) : DEN_W'(shifted);
        quo_q  <= {quo_q[NUM_W-2:0], fits};
        step_q <= step_q - 1'b1;
        if (step_q == StepW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  a_r8_div_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r3_rem_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q));
endmodule

// File: rtl/hha_avg.sv
module hha_avg
  import hha_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 120,
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 7,
  parameter int SUM_W  = 31
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     capture_i,
  input  logic                     valid_i,
  input  logic        [CNT_W-1:0]  win_i,
  input  logic        [CNT_W-1:0]  dly_i,
  input  logic        [PTR_W-1:0]  wr_ptr_i,
  output logic        [PTR_W-1:0]  rd_idx_o,
  input  logic signed [DATA_W-1:0] rd_data_i,
  output logic signed [DATA_W-1:0] avg_o,
  output logic                     done_o
);
  localparam int AddW = CNT_W + 1;

  avg_state_e               state_q;
  logic signed [SUM_W-1:0]  sum_q;
  logic        [CNT_W-1:0]  cnt_q, wlen_q, use_w, use_d;
  logic        [PTR_W-1:0]  rd_idx_q, start_idx;
  logic                     neg_q, done_q;
  logic signed [DATA_W-1:0] avg_q;
  logic        [AddW-1:0]   idx_t;
  logic        [SUM_W-1:0]  mag;
  logic                     div_start, div_busy, div_done;
  logic        [SUM_W-1:0]  quo;

  // not yet valid: fall back to the newest recorded sample
  assign use_w = valid_i ? win_i : CNT_W'(1);
  assign use_d = valid_i ? dly_i : '0;

  always_comb begin
    idx_t = AddW'(wr_ptr_i) + AddW'(DEPTH - 1) - AddW'(use_d);
    if (idx_t >= AddW'(DEPTH)) idx_t = idx_t - AddW'(DEPTH);
    start_idx = PTR_W'(idx_t);
  end

  assign mag       = sum_q[SUM_W-1] ? SUM_W'(-sum_q) : SUM_W'(sum_q);
  assign div_start = (state_q == ST_LOAD);

  hha_div #(.NUM_W(SUM_W), .DEN_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (mag),
    .den_i  (wlen_q),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sum_q    <= '0;
      cnt_q    <= '0;
      wlen_q   <= CNT_W'(1);
      rd_idx_q <= '0;
      neg_q    <= 1'b0;
      avg_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (capture_i) begin
          cnt_q    <= use_w;
          wlen_q   <= use_w;
          rd_idx_q <= start_idx;
          sum_q    <= '0;
          state_q  <= ST_ACC;
        end
        ST_ACC: begin
          sum_q    <= sum_q + SUM_W'(rd_data_i);
          rd_idx_q <= (rd_idx_q == '0) ? PTR_W'(DEPTH - 1) : rd_idx_q - 1'b1;
          cnt_q    <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          neg_q   <= sum_q[SUM_W-1];
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (div_done) begin
          avg_q   <= neg_q ? -DATA_W'(quo) : DATA_W'(quo);
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_idx_o = rd_idx_q;
  assign avg_o    = avg_q;
  assign done_o   = done_q;

  a_r9_hold_between_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(avg_q));
  a_r8_done_returns_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));
  a_r3_quo_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> (quo[SUM_W-1:DATA_W] == '0));
  a_r8_div_idle_when_fsm_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !div_busy);
endmodule

// File: rtl/holdover_hist_avg.sv
module holdover_hist_avg #(
  parameter int DATA_W  = 24,
  parameter int DEPTH   = 120,
  parameter int DEF_WIN = 9,
  parameter int DEF_DLY = 2,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int SUM_W  = DATA_W + CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic              locked_i,
  input  logic [CNT_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  dly_len_i,
  input  logic              capture_i,
  output logic [DATA_W-1:0] avg_o,
  output logic              avg_done_o,
  output logic              hist_valid_o
);
  logic        [CNT_W-1:0]  win_eff, dly_eff, run_cnt;
  logic        [PTR_W-1:0]  wr_ptr, rd_idx;
  logic signed [DATA_W-1:0] rd_data, avg_s;

  hha_clamp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DEF_WIN(DEF_WIN), .DEF_DLY(DEF_DLY)) u_clamp (
    .win_i(win_len_i),
    .dly_i(dly_len_i),
    .win_o(win_eff),
    .dly_o(dly_eff)
  );

  hha_history #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    ($signed(sample_i)),
    .sample_vld_i(sample_vld_i),
    .locked_i    (locked_i),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .wr_ptr_o    (wr_ptr),
    .run_cnt_o   (run_cnt)
  );

  assign hist_valid_o = run_cnt >= CNT_W'(win_eff + dly_eff);

  hha_avg #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_avg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture_i),
    .valid_i  (hist_valid_o),
    .win_i    (win_eff),
    .dly_i    (dly_eff),
    .wr_ptr_i (wr_ptr),
    .rd_idx_o (rd_idx),
    .rd_data_i(rd_data),
    .avg_o    (avg_s),
    .done_o   (avg_done_o)
  );

  assign avg_o = avg_s;

  a_r6_valid_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> !hist_valid_o);
  a_r5_clamped_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((CNT_W + 1)'(win_eff) + (CNT_W + 1)'(dly_eff)) <= (CNT_W + 1)'(DEPTH));
endmodule

// File: tb/holdover_hist_avg_tb_top.sv
`timescale 1ns/1ps
module holdover_hist_avg_tb_top;
  localparam int DATA_W = 24;
  localparam int DEPTH  = 120;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DATA_W-1:0] sample_i = '0;
  logic              sample_vld_i = 1'b0;
  logic              locked_i = 1'b0;
  logic [CNT_W-1:0]  win_len_i = '0;
  logic [CNT_W-1:0]  dly_len_i = '0;
  logic              capture_i = 1'b0;
  logic [DATA_W-1:0] avg_o;
  logic              avg_done_o;
  logic              hist_valid_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int hist[$];
  int run = 0;

  always #10 clk_i = ~clk_i;

  holdover_hist_avg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
    .locked_i(locked_i), .win_len_i(win_len_i), .dly_len_i(dly_len_i),
    .capture_i(capture_i), .avg_o(avg_o), .avg_done_o(avg_done_o),
    .hist_valid_o(hist_valid_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void eff(input int win, input int dly, output int w, output int d);
    w = (win == 0) ? 9 : win;
    d = (win == 0) ? 2 : dly;
    if (w > DEPTH) w = DEPTH;
    if (d > DEPTH - w) d = DEPTH - w;
  endfunction

  function automatic bit exp_valid(input int win, input int dly);
    int w, d;
    eff(win, dly, w, d);
    return run >= w + d;
  endfunction

  function automatic int exp_avg(input int win, input int dly);
    int w, d, n;
    longint s;
    eff(win, dly, w, d);
    n = hist.size();
    if (run < w + d) return (n == 0) ? 0 : hist[n-1];
    s = 0;
    for (int k = 0; k < w; k++) s += hist[n-1-d-k];
    return int'(s / w);
  endfunction

  task automatic send(input int v);
    @(negedge clk_i);
    sample_i = DATA_W'(v);
    sample_vld_i = 1'b1;
    @(negedge clk_i);
    sample_vld_i = 1'b0;
    if (locked_i) begin
      hist.push_back(v);
      if (run < DEPTH) run++;
    end
  endtask

  task automatic capture(output int got, output bit seen);
    seen = 1'b0;
    got = 0;
    @(negedge clk_i);
    capture_i = 1'b1;
    @(negedge clk_i);
    capture_i = 1'b0;
    for (int i = 0; i < 600 && !seen; i++) begin
      @(negedge clk_i);
      if (avg_done_o) begin
        seen = 1'b1;
        got = int'($signed(avg_o));
      end
    end
  endtask

  task automatic cap_check(input string req);
    int got, e;
    bit seen;
    e = exp_avg(int'(win_len_i), int'(dly_len_i));
    capture(got, seen);
    chk(seen, {req, " done"}, seen, 1);
    chk(got == e, req, got, e);
  endtask

  task automatic t_reset;
    chk(avg_o == '0, "R10 avg", avg_o, 0);
    chk(!avg_done_o, "R10 done", avg_done_o, 0);
    chk(!hist_valid_o, "R10 valid", hist_valid_o, 0);
  endtask

  task automatic t_empty_capture;
    win_len_i = CNT_W'(4); dly_len_i = CNT_W'(2);
    cap_check("R7 empty history");
  endtask

  task automatic t_basic;
    locked_i = 1'b1;
    @(negedge clk_i);
    for (int k = 1; k <= 5; k++) send(100 * k + 3);
    chk(hist_valid_o == 1'b0, "R6 five of six", hist_valid_o, 0);
    send(603);
    chk(hist_valid_o == 1'b1, "R6 six of six", hist_valid_o, 1);
    for (int k = 7; k <= 10; k++) send(100 * k + 3);
    cap_check("R3 ramp window 4 delay 2");
  endtask

  task automatic t_negative;
    win_len_i = CNT_W'(3); dly_len_i = CNT_W'(1);
    send(-10); send(-11); send(-13); send(-8);
    cap_check("R3 negative truncation");
    win_len_i = CNT_W'(7); dly_len_i = CNT_W'(0);
    send(-8388608); send(5); send(-3);
    cap_check("R3 mixed sign window 7");
  endtask

  task automatic t_default;
    win_len_i = '0; dly_len_i = CNT_W'(50);
    chk(hist_valid_o == exp_valid(0, 50), "R4 default valid", hist_valid_o, exp_valid(0, 50));
    cap_check("R4 default window and delay");
  endtask

  task automatic t_unlock;
    int got, e;
    bit seen;
    win_len_i = CNT_W'(4); dly_len_i = CNT_W'(2);
    locked_i = 1'b0;
    run = 0;
    @(negedge clk_i); @(negedge clk_i);
    chk(hist_valid_o == 1'b0, "R6 lock loss clears", hist_valid_o, 0);
    send(999999);
    locked_i = 1'b1;
    send(70); send(71);
    e = hist[hist.size()-1];
    capture(got, seen);
    chk(got == e, "R2 R7 unlocked strobe ignored, last sample", got, e);
    send(72); send(73); send(74);
    chk(hist_valid_o == 1'b0, "R6 rebuild five", hist_valid_o, 0);
    send(75);
    chk(hist_valid_o == 1'b1, "R6 rebuild six", hist_valid_o, 1);
    cap_check("R3 post relock window");
  endtask

  task automatic t_clamp;
    locked_i = 1'b0; run = 0;
    @(negedge clk_i);
    locked_i = 1'b1;
    win_len_i = CNT_W'(127); dly_len_i = CNT_W'(9);
    for (int k = 0; k < DEPTH - 1; k++) send(k * 37 - 2000);
    chk(hist_valid_o == 1'b0, "R5 clamped needs 120", hist_valid_o, 0);
    send(4321);
    chk(hist_valid_o == 1'b1, "R5 R1 full depth valid", hist_valid_o, 1);
    cap_check("R5 R1 window clamped to depth");
    win_len_i = CNT_W'(100); dly_len_i = CNT_W'(50);
    send(-777); send(12345);
    cap_check("R5 delay clamped to 20");
  endtask

  task automatic t_hold_busy;
    int pulses, held;
    win_len_i = CNT_W'(5); dly_len_i = CNT_W'(3);
    pulses = 0;
    @(negedge clk_i);
    capture_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    capture_i = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (avg_done_o) pulses++;
    end
    chk(pulses == 1, "R8 capture while busy ignored", pulses, 1);
    held = int'($signed(avg_o));
    chk(held == exp_avg(5, 3), "R3 value of busy capture", held, exp_avg(5, 3));
    send(500000); send(-500000);
    win_len_i = CNT_W'(2); dly_len_i = CNT_W'(0);
    repeat (5) @(negedge clk_i);
    chk(int'($signed(avg_o)) == held, "R9 held after new samples", int'($signed(avg_o)), held);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_empty_capture();
    t_basic();
    t_negative();
    t_default();
    t_unlock();
    t_clamp();
    t_hold_busy();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule